// File: doc/BRIEF.md
# Programmable-Frame Asynchronous Serial Transmitter

This block turns one parallel character at a time into an asynchronous serial frame on a single output line. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, and finally a high stop period of one, one and a half or two bit times. The line rests high between frames.

Timing comes from an enable pulse supplied at sixteen times the bit rate. A bit lasts `TICKS_PER_BIT` pulses (16 by default), and a half stop bit lasts half that many. A character is handed over with a valid/ready handshake. A 4-bit format input and a parity-sense input are captured together with the character, so the surrounding logic may change them at any time without disturbing a frame already in flight.

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `txd` is 1, `busy` is 0 and `tx_ready` is 1. A reset in mid-frame returns the line to this state.
- R2: A character is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both 1. From the next cycle `busy` is 1 and `tx_ready` is 0 until the frame ends. While busy, `tx_valid` and `tx_data` have no effect on the frame being sent.
- R3: The frame begins with a start bit: `txd` is 0 for 16 ticks, starting the cycle after acceptance.
- R4: Format bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent LSB first for 16 ticks each. Bits of `tx_data` above the word length are not sent.
- R5: When format bit [3] is 1, one parity bit follows the data bits. When `odd_par` is 0 it makes the count of ones over the active data bits plus parity even. When `odd_par` is 1 it makes that count odd.
- R6: When format bit [3] is 0, no parity bit is sent, and the stop period follows the last data bit directly.
- R7: When format bit [2] is 0, the stop period is one bit time (16 ticks) at level 1, for any word length.
- R8: When format bit [2] is 1 and the word length is 5, the stop period is 24 ticks at level 1.
- R9: When format bit [2] is 1 and the word length is 6, 7 or 8, the stop period is 32 ticks at level 1.
- R10: The format and `odd_par` are sampled at acceptance. Changing them during a frame affects only later characters. `busy` falls exactly 16·(1 + data bits + parity bits) + stop ticks after acceptance.
- R11: A frame advances only on cycles where `tick16` is 1. Without ticks, `txd` and `busy` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Enable pulse at 16x the bit rate |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | Character offered |
| tx_ready | output | 1 | Block can accept a character |
| fmt | input | 4 | [1:0] word length, [2] long stop, [3] parity enable |
| odd_par | input | 1 | 1 selects odd parity, 0 selects even parity |
| txd | output | 1 | Serial output line |
| busy | output | 1 | A frame is in progress |

## Verification
A corrupted phase or bit index shows up directly on `txd`. A data or parity value sampled in the middle of a bit differs from the value the bench computes, so the error is seen within the same bit time. A wrong tick counter or stop-length decode moves the falling edge of `busy`. The bench compares that edge with the exact tick count of the frame, so the error is caught when the frame ends. A format latch that follows the live input is exposed because the bench inverts the format, parity sense and data right after acceptance, which changes the frame's bits and its length.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_START,
      PH_DATA,
      PH_PAR,
      PH_STOP
   } phase_t;

   // Frame settings captured when a character is accepted
   typedef struct packed {
      logic [3:0] nbits;        // 5..8 data bits
      logic       par_en;       // parity bit present
      logic       par_odd;      // odd sense when set
      logic [2:0] stop_halves;  // stop length in half bit times: 2, 3 or 4
   } frame_cfg_t;

endpackage

// File: rtl/uftx_fmt_dec.sv
module uftx_fmt_dec
   import uftx_pkg::*;
#(
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic [3:0] fmt,
   input  logic       odd_par,
   output frame_cfg_t cfg
);

   logic par_en_w;
   logic par_odd_w;

   generate
      if (PARITY_SUPPORT) begin : g_par
         assign par_en_w  = fmt[3];
         assign par_odd_w = odd_par;
      end else begin : g_nopar
         assign par_en_w  = 1'b0;
         assign par_odd_w = 1'b0;
      end
   endgenerate

   always_comb begin
      cfg.nbits   = 4'd5 + {2'b00, fmt[1:0]};
      cfg.par_en  = par_en_w;
      cfg.par_odd = par_odd_w;
      if (!fmt[2])
         cfg.stop_halves = 3'd2;
      else if (fmt[1:0] == 2'b00)
         cfg.stop_halves = 3'd3;
      else
         cfg.stop_halves = 3'd4;
   end

endmodule

// File: rtl/uftx_bit_timer.sv
module uftx_bit_timer #(
   parameter int unsigned LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   input  logic [LEN_W-1:0] len,
   output logic             done
);

   logic [LEN_W-1:0] cnt_q;

   assign done = tick && (cnt_q == len - LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (restart)
         cnt_q <= '0;
      else if (tick)
         cnt_q <= cnt_q + LEN_W'(1);
   end

endmodule

// File: rtl/uftx_shreg.sv
module uftx_shreg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   input  logic [3:0]   nbits,
   input  logic         odd,
   output logic         cur_bit,
   output logic         next_bit,
   output logic         par_bit
);

   logic [W-1:0] mask;
   logic [W-1:0] sh_q;
   logic         par_q;

   // Only the active data bits count, so the unused upper bits are masked off.
   generate
      for (genvar i = 0; i < W; i++) begin : g_mask
         assign mask[i] = (4'(i) < nbits);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         par_q <= 1'b0;
      end else if (load) begin
         sh_q  <= din & mask;
         par_q <= (^(din & mask)) ^ odd;
      end else if (shift) begin
         sh_q  <= sh_q >> 1;
      end
   end

   assign cur_bit  = sh_q[0];
   assign next_bit = sh_q[1];
   assign par_bit  = par_q;

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
   import uftx_pkg::*;
#(
   parameter int unsigned TICKS_PER_BIT  = 16,
   parameter int unsigned DATA_W         = 8,
   parameter bit          PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [3:0]        fmt,
   input  logic              odd_par,
   output logic              txd,
   output logic              busy
);

   localparam int unsigned HALF_TICKS = TICKS_PER_BIT / 2;
   localparam int unsigned LEN_W      = $clog2(2 * TICKS_PER_BIT + 1);

   generate
      if (TICKS_PER_BIT < 2 || (TICKS_PER_BIT % 2) != 0) begin : g_bad_ticks
         $error("TICKS_PER_BIT must be even and at least 2");
      end
      if (DATA_W != 8) begin : g_bad_width
         $error("DATA_W must be 8 to carry 5..8 bit characters");
      end
   endgenerate

   phase_t     ph_q;
   frame_cfg_t cfg_d, cfg_q;
   logic [2:0] idx_q;
   logic       txd_q;
   logic       accept, bit_done, adv, last_data;
   logic       cur_bit, next_bit, par_bit;
   logic       sh_shift;
   logic [LEN_W-1:0] phase_len, stop_len;

   uftx_fmt_dec #(.PARITY_SUPPORT(PARITY_SUPPORT)) u_dec (
      .fmt     (fmt),
      .odd_par (odd_par),
      .cfg     (cfg_d)
   );

   assign stop_len  = LEN_W'(cfg_q.stop_halves) * LEN_W'(HALF_TICKS);
   assign phase_len = (ph_q == PH_STOP) ? stop_len : LEN_W'(TICKS_PER_BIT);

   uftx_bit_timer #(.LEN_W(LEN_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept || adv),
      .tick    (tick16),
      .len     (phase_len),
      .done    (bit_done)
   );

   assign busy      = (ph_q != PH_IDLE);
   assign tx_ready  = !busy;
   assign accept    = tx_valid && !busy;
   assign adv       = busy && bit_done;
   assign last_data = ({1'b0, idx_q} == cfg_q.nbits - 4'd1);
   assign sh_shift  = adv && (ph_q == PH_DATA) && !last_data;

   uftx_shreg #(.W(DATA_W)) u_shreg (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (accept),
      .shift    (sh_shift),
      .din      (tx_data),
      .nbits    (cfg_d.nbits),
      .odd      (cfg_d.par_odd),
      .cur_bit  (cur_bit),
      .next_bit (next_bit),
      .par_bit  (par_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cfg_q <= '{nbits: 4'd5, par_en: 1'b0, par_odd: 1'b0, stop_halves: 3'd2};
         idx_q <= '0;
         txd_q <= 1'b1;
      end else if (accept) begin
         ph_q  <= PH_START;
         cfg_q <= cfg_d;
         idx_q <= '0;
         txd_q <= 1'b0;
      end else if (adv) begin
         unique case (ph_q)
            PH_START: begin
               ph_q  <= PH_DATA;
               txd_q <= cur_bit;
            end
            PH_DATA: begin
               if (!last_data) begin
                  idx_q <= idx_q + 3'd1;
                  txd_q <= next_bit;
               end else if (cfg_q.par_en) begin
                  ph_q  <= PH_PAR;
                  txd_q <= par_bit;
               end else begin
                  ph_q  <= PH_STOP;
                  txd_q <= 1'b1;
               end
            end
            PH_PAR: begin
               ph_q  <= PH_STOP;
               txd_q <= 1'b1;
            end
            PH_STOP: begin
               ph_q  <= PH_IDLE;
               txd_q <= 1'b1;
            end
            default: begin
               ph_q  <= PH_IDLE;
               txd_q <= 1'b1;
            end
         endcase
      end
   end

   assign txd = txd_q;

endmodule

// File: rtl/uftx_chk.sv
module uftx_chk (
   input logic clk,
   input logic rst_n,
   input logic tick16,
   input logic tx_valid,
   input logic tx_ready,
   input logic txd,
   input logic busy
);

   // R1: idle line is high and ready
   a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (txd && tx_ready));

   // R2: ready is withdrawn for the whole frame
   a_r2_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !tx_ready);

   // R2 / R3: acceptance starts a frame with the start bit
   a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> (busy && !txd));

   // R7: the line is high in the cycles around the end of a frame
   a_r7_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (txd && $past(txd)));

   // R11: with no tick the frame is frozen
   a_r11_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick16) |=> (busy && $stable(txd)));

endmodule

bind uart_frame_tx uftx_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick16   (tick16),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .txd      (txd),
   .busy     (busy)
);

// File: tb/uart_frame_tx_tb.sv
module uart_frame_tx_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b1;
   logic [7:0] tx_data = '0;
   logic       tx_valid = 1'b0;
   logic       tx_ready;
   logic [3:0] fmt = '0;
   logic       odd_par = 1'b0;
   logic       txd;
   logic       busy;

   int n_total = 0;
   int n_pass  = 0;

   always #5 clk = ~clk;

   uart_frame_tx u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick16   (tick16),
      .tx_data  (tx_data),
      .tx_valid (tx_valid),
      .tx_ready (tx_ready),
      .fmt      (fmt),
      .odd_par  (odd_par),
      .txd      (txd),
      .busy     (busy)
   );

   // {odd_par, fmt[3:0], data[7:0]}
   localparam int NV = 13;
   localparam logic [12:0] VEC [NV] = '{
      {1'b0, 4'b0000, 8'h15},
      {1'b0, 4'b0001, 8'h2A},
      {1'b0, 4'b0010, 8'h55},
      {1'b0, 4'b0011, 8'hA5},
      {1'b0, 4'b0100, 8'hE5},
      {1'b0, 4'b0101, 8'h3C},
      {1'b0, 4'b1011, 8'h81},
      {1'b1, 4'b1011, 8'h81},
      {1'b1, 4'b1000, 8'h1F},
      {1'b0, 4'b1110, 8'h7F},
      {1'b1, 4'b1100, 8'h00},
      {1'b0, 4'b0111, 8'hFF},
      {1'b1, 4'b1111, 8'h6B}
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_total++;
      if (ok) n_pass++;
      else $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_pass, n_total);
   endtask

   // Send one character; optionally hold tick16 low for 'stall' cycles after acceptance
   task automatic send(input logic [7:0] d, input logic [3:0] f, input logic o, input int stall);
      int    n, p, stop, nb, total, c;
      logic  par;
      logic  [7:0] dm;
      string stag;
      n     = 5 + int'(f[1:0]);
      p     = f[3] ? 1 : 0;
      stop  = !f[2] ? 16 : ((n == 5) ? 24 : 32);
      stag  = !f[2] ? "R7" : ((n == 5) ? "R8" : "R9");
      nb    = 1 + n + p;
      total = 16 * nb + stop;
      dm    = d & 8'((9'h1 << n) - 9'h1);
      par   = (^dm) ^ o;

      @(negedge clk);
      tx_data  = d;
      fmt      = f;
      odd_par  = o;
      tx_valid = 1'b1;
      tick16   = (stall == 0);
      @(posedge clk);
      @(negedge clk);
      check(busy == 1'b1, "R2 busy after accept", int'(busy), 1);
      check(tx_ready == 1'b0, "R2 ready low in frame", int'(tx_ready), 0);
      // Offer a different character and format: must be ignored for this frame (R2, R10)
      tx_data = ~d;
      fmt     = ~f;
      odd_par = ~o;
      for (int i = 0; i < stall; i++) begin
         check(busy && !txd, "R11 frozen without tick", int'({busy, txd}), 2);
         @(posedge clk);
         @(negedge clk);
      end
      tick16 = 1'b1;
      c = 0;
      forever begin
         if (c == 20) tx_valid = 1'b0;
         if ((c % 16) == 8 && c < 16 * nb) begin
            if (c / 16 == 0)
               check(txd == 1'b0, "R3 start bit", int'(txd), 0);
            else if (c / 16 <= n)
               check(txd == d[c/16 - 1], "R4 data bit", int'(txd), int'(d[c/16 - 1]));
            else
               check(txd == par, "R5 parity bit", int'(txd), int'(par));
         end
         if (p == 0 && c == 16 * (1 + n) + 8)
            check(txd == 1'b1, "R6 no parity, stop follows", int'(txd), 1);
         if (c == 16 * nb + 4)
            check(txd == 1'b1, {stag, " stop level"}, int'(txd), 1);
         if (c == total - 1)
            check(busy && txd, {stag, " R10 stop not cut short"}, int'({busy, txd}), 3);
         if (c == total) begin
            check(!busy && tx_ready && txd, {stag, " R10 frame end R1 idle"},
                  int'({busy, tx_ready, txd}), 3);
            break;
         end
         @(posedge clk);
         @(negedge clk);
         c++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_total++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(txd == 1'b1, "R1 reset txd", int'(txd), 1);
      check(busy == 1'b0, "R1 reset busy", int'(busy), 0);
      check(tx_ready == 1'b1, "R1 reset ready", int'(tx_ready), 1);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector table
      for (int v = 0; v < NV; v++)
         send(VEC[v][7:0], VEC[v][11:8], VEC[v][12], 0);

      // R11: stalled tick at frame start
      send(8'h96, 4'b1011, 1'b0, 30);

      // R1: reset in mid-frame
      @(negedge clk);
      tx_data  = 8'h00;
      fmt      = 4'b0011;
      tx_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      repeat (40) @(negedge clk);
      check(busy == 1'b1, "R1 frame running before reset", int'(busy), 1);
      rst_n = 1'b0;
      @(negedge clk);
      check(txd && !busy && tx_ready, "R1 mid-frame reset", int'({txd, busy, tx_ready}), 5);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: back-to-back character after reset still framed correctly
      send(8'h0A, 4'b0000, 1'b0, 0);

      summary();
      $finish;
   end

endmodule